// File: doc/BRIEF.md
# Self-Timed Byte-Wide Nonvolatile Memory Controller

This block models the control side of a byte-wide nonvolatile memory that a host drives through an asynchronous, SRAM-like pin set: active-low chip select, output enable and write enable, a 13-bit address and a bidirectional data bus. The bus is split into an input, an output and an output-enable. The block runs inside a clocked design. It synchronises the strobes to the system clock and works out from their edges when a host read or write takes place. Storage is a register array written so that it can map onto block RAM.

A byte write is latched from whichever strobe, chip select or write enable, forms the pulse. The address is taken when the pulse begins and the data when it ends. An internal timer then completes the write with no further host action. During that time an open-drain style busy output pulls low, and reads return a status pattern instead of array data. Writes are refused for a fixed time after reset, when output enable is low, and while a write is already running.

Two side inputs stand in for high-voltage conditions. One, held together with a long write pulse, erases the whole main array to all ones. The other opens a separate 32-byte identification area at the top of the address space.

Top module: `nvbyte_ctrl`

## Requirements
- R1: With cs_n low, oe_n low and we_n held high, dq_oe goes to 1 and dq_out shows the byte stored at the selected location, settled within 6 clock cycles of the inputs becoming stable.
- R2: Whenever cs_n or oe_n has been high for 4 cycles, dq_oe is 0 and dq_out is 0.
- R3: In a write-enable-controlled write (cs_n low, oe_n high, we_n pulsed low), the address is the one present when we_n falls and the data is the one present when we_n rises. Later address changes and earlier data values are not used.
- R4: In a chip-select-controlled write (we_n low, oe_n high, cs_n pulsed low), the same capture rule applies to the edges of cs_n.
- R5: After the strobe that ends an accepted write, busy_pull is 1 for exactly WR_CYCLES consecutive clock cycles and then returns to 0. From then on, reads return the new byte.
- R6: While busy_pull is 1, a read of any location returns the complement of bit 7 of the byte being written on bit 7, with bits 6:0 read as 0.
- R7: A write strobe is ignored if oe_n is low during it. A write strobe that begins while busy_pull is 1 is also ignored. In both cases the array and busy_pull stay unchanged.
- R8: A write strobe that ends within PWRUP_CYCLES cycles after reset is released is ignored.
- R9: With clr_hv high, cs_n low and we_n low held for at least CLR_CYCLES cycles, every main-array byte becomes 8'hFF and busy_pull is 1 for 2**MAIN_AW cycles. A shorter hold changes nothing.
- R10: With id_sel high and addr[12:5] all ones, reads and writes use a separate 32-byte area indexed by addr[4:0]. Otherwise the main array is used, indexed by addr[MAIN_AW-1:0], and a write to one area leaves the other unchanged.
- R11: During reset, busy_pull, dq_oe and dq_out are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, treated as power-up |
| cs_n | input | 1 | Chip select, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| clr_hv | input | 1 | Erase qualifier, stands in for the high-voltage output-enable level |
| id_sel | input | 1 | Identification-area qualifier, stands in for the high-voltage address level |
| addr | input | ADDR_W | Byte address |
| dq_in | input | DATA_W | Data bus, inbound half |
| dq_out | output | DATA_W | Data bus, outbound half (0 when not driven) |
| dq_oe | output | 1 | Data bus drive enable |
| busy_pull | output | 1 | 1 while the ready/busy line is pulled low, 0 when released |

## Verification
The hardest case to reach is a read issued during a running write cycle. The host has to finish the write strobe and then, before the timer expires, open a read while the strobes pass through the synchroniser. The bench shortens the write timer by parameter, keeps chip select low after the write pulse, and lowers output enable a few cycles after write enable rises. The read therefore samples inside the busy window, and the status pattern can be compared before true data returns. The same approach places a second write strobe inside the busy window, and places a write strobe inside the post-reset lockout window by issuing it right after reset.

// File: rtl/nvbyte_pkg.sv
package nvbyte_pkg;

  // synchronised host controls, most significant field first
  typedef struct packed {
    logic cs_n;
    logic oe_n;
    logic we_n;
    logic clr;
  } ctl_t;

  localparam int CTL_W = $bits(ctl_t);
  // idle level of each control after reset: strobes high, erase qualifier low
  localparam logic [CTL_W-1:0] CTL_IDLE = 4'b1110;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_PROG  = 2'd1,
    SQ_SWEEP = 2'd2
  } sq_state_e;

endpackage

// File: rtl/nvbyte_sync.sv
module nvbyte_sync #(
  parameter int                W       = 4,
  parameter int                STAGES  = 2,
  parameter logic [W-1:0]      RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  localparam int LAST = STAGES - 1;

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[b]}};
      else     chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[LAST];
  end

endmodule

// File: rtl/nvbyte_store.sv
module nvbyte_store #(
  parameter int DATA_W  = 8,
  parameter int MAIN_AW = 8,
  parameter int ID_AW   = 5
) (
  input  logic               clk,
  input  logic               wr_en,
  input  logic               wr_id,
  input  logic [MAIN_AW-1:0] wr_main_addr,
  input  logic [ID_AW-1:0]   wr_id_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               rd_id,
  input  logic [MAIN_AW-1:0] rd_main_addr,
  input  logic [ID_AW-1:0]   rd_id_addr,
  output logic [DATA_W-1:0]  rdata
);

  localparam int MAIN_DEPTH = 1 << MAIN_AW;
  localparam int ID_DEPTH   = 1 << ID_AW;

  logic [DATA_W-1:0] main_mem [MAIN_DEPTH];
  logic [DATA_W-1:0] id_mem   [ID_DEPTH];
  logic [DATA_W-1:0] main_q, id_q;
  logic              sel_q;

  // one write port and one registered read port per array
  always_ff @(posedge clk) begin
    if (wr_en && !wr_id) main_mem[wr_main_addr] <= wr_data;
    main_q <= main_mem[rd_main_addr];
  end

  always_ff @(posedge clk) begin
    if (wr_en && wr_id) id_mem[wr_id_addr] <= wr_data;
    id_q <= id_mem[rd_id_addr];
  end

  always_ff @(posedge clk) sel_q <= rd_id;

  assign rdata = sel_q ? id_q : main_q;

endmodule

// File: rtl/nvbyte_seq.sv
module nvbyte_seq
  import nvbyte_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int MAIN_AW      = 8,
  parameter int ID_AW        = 5,
  parameter int WR_CYCLES    = 25000,
  parameter int PWRUP_CYCLES = 625000,
  parameter int CLR_CYCLES   = 1250000
) (
  input  logic               clk,
  input  logic               rst,
  input  ctl_t               ctl,
  input  logic               id_hit,
  input  logic [MAIN_AW-1:0] addr,
  input  logic [DATA_W-1:0]  din,
  output logic               busy,
  output logic [DATA_W-1:0]  poll,
  output logic               wr_en,
  output logic               wr_id,
  output logic [MAIN_AW-1:0] wr_main_addr,
  output logic [ID_AW-1:0]   wr_id_addr,
  output logic [DATA_W-1:0]  wr_data
);

  localparam int TW = $clog2(WR_CYCLES + 1);
  localparam int LW = $clog2(PWRUP_CYCLES + 1);
  localparam int CW = $clog2(CLR_CYCLES + 1);
  localparam logic [TW-1:0]      T_LAST  = TW'(WR_CYCLES - 1);
  localparam logic [LW-1:0]      L_LAST  = LW'(PWRUP_CYCLES - 1);
  localparam logic [CW-1:0]      C_LAST  = CW'(CLR_CYCLES - 1);
  localparam logic [MAIN_AW-1:0] P_LAST  = '1;
  localparam logic [DATA_W-1:0]  ERASED  = '1;

  sq_state_e          state;
  logic [TW-1:0]      tmr;
  logic               first;
  logic [LW-1:0]      lock_cnt;
  logic               unlocked;
  logic               strobe, strobe_q, start, stop;
  logic               pend;
  logic [MAIN_AW-1:0] lat_addr;
  logic               lat_id;
  logic [DATA_W-1:0]  lat_data;
  logic [MAIN_AW-1:0] sweep_ptr;
  logic               clr_cond, clr_hold, clr_go;
  logic [CW-1:0]      clr_cnt;

  // write strobe: both enables low, output enable high, no erase request
  assign strobe   = !ctl.cs_n && !ctl.we_n && ctl.oe_n && !ctl.clr;
  assign start    = strobe && !strobe_q;
  assign stop     = !strobe && strobe_q;
  assign clr_cond = ctl.clr && !ctl.cs_n && !ctl.we_n;
  assign clr_go   = clr_cond && !clr_hold && (clr_cnt == C_LAST)
                    && unlocked && (state == SQ_IDLE);

  // power-up lockout
  always_ff @(posedge clk) begin
    if (rst) begin
      lock_cnt <= '0;
      unlocked <= 1'b0;
    end else if (!unlocked) begin
      if (lock_cnt == L_LAST) unlocked <= 1'b1;
      else                    lock_cnt <= lock_cnt + 1'b1;
    end
  end

  // erase pulse width measurement
  always_ff @(posedge clk) begin
    if (rst || !clr_cond) begin
      clr_cnt  <= '0;
      clr_hold <= 1'b0;
    end else if (!clr_hold) begin
      if (clr_cnt == C_LAST) clr_hold <= 1'b1;
      else                   clr_cnt  <= clr_cnt + 1'b1;
    end
  end

  // request capture and timed cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      strobe_q  <= 1'b0;
      pend      <= 1'b0;
      tmr       <= '0;
      first     <= 1'b0;
      lat_addr  <= '0;
      lat_id    <= 1'b0;
      lat_data  <= '0;
      sweep_ptr <= '0;
    end else begin
      strobe_q <= strobe;
      case (state)
        SQ_IDLE: begin
          if (start && unlocked) begin
            pend     <= 1'b1;
            lat_addr <= addr;
            lat_id   <= id_hit;
          end
          if (stop && pend) begin
            pend     <= 1'b0;
            lat_data <= din;
            tmr      <= T_LAST;
            first    <= 1'b1;
            state    <= SQ_PROG;
          end
          if (clr_go) begin
            pend      <= 1'b0;
            sweep_ptr <= '0;
            state     <= SQ_SWEEP;
          end
        end
        SQ_PROG: begin
          first <= 1'b0;
          if (tmr == '0) state <= SQ_IDLE;
          else           tmr   <= tmr - 1'b1;
        end
        SQ_SWEEP: begin
          if (sweep_ptr == P_LAST) state     <= SQ_IDLE;
          else                     sweep_ptr <= sweep_ptr + 1'b1;
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  assign busy = (state != SQ_IDLE);

  // erase the target on the first cycle, program it on the last
  always_comb begin
    wr_en        = 1'b0;
    wr_id        = lat_id;
    wr_main_addr = lat_addr;
    wr_id_addr   = lat_addr[ID_AW-1:0];
    wr_data      = lat_data;
    poll         = {~lat_data[DATA_W-1], {(DATA_W-1){1'b0}}};
    if (state == SQ_PROG) begin
      wr_en = first || (tmr == '0);
      if (tmr != '0) wr_data = ERASED;
    end else if (state == SQ_SWEEP) begin
      wr_en        = 1'b1;
      wr_id        = 1'b0;
      wr_main_addr = sweep_ptr;
      wr_data      = ERASED;
      poll         = {~ERASED[DATA_W-1], {(DATA_W-1){1'b0}}};
    end
  end

endmodule

// File: rtl/nvbyte_ctrl.sv
module nvbyte_ctrl
  import nvbyte_pkg::*;
#(
  parameter int ADDR_W       = 13,
  parameter int DATA_W       = 8,
  parameter int MAIN_AW      = 8,
  parameter int ID_AW        = 5,
  parameter int WR_CYCLES    = 25000,
  parameter int PWRUP_CYCLES = 625000,
  parameter int CLR_CYCLES   = 1250000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic              clr_hv,
  input  logic              id_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              busy_pull
);

  logic [CTL_W-1:0]   ctl_raw, ctl_sync;
  ctl_t               ctl;
  logic               id_hit, rd_en, busy;
  logic [DATA_W-1:0]  poll, rdata, wr_data;
  logic               wr_en, wr_id;
  logic [MAIN_AW-1:0] wr_main_addr;
  logic [ID_AW-1:0]   wr_id_addr;

  assign ctl_raw = {cs_n, oe_n, we_n, clr_hv};

  nvbyte_sync #(.W(CTL_W), .STAGES(2), .RST_VAL(CTL_IDLE)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (ctl_raw),
    .q   (ctl_sync)
  );

  assign ctl    = ctl_t'(ctl_sync);
  assign id_hit = id_sel && (&addr[ADDR_W-1:ID_AW]);
  assign rd_en  = !ctl.cs_n && !ctl.oe_n && ctl.we_n;

  nvbyte_seq #(
    .DATA_W(DATA_W), .MAIN_AW(MAIN_AW), .ID_AW(ID_AW),
    .WR_CYCLES(WR_CYCLES), .PWRUP_CYCLES(PWRUP_CYCLES), .CLR_CYCLES(CLR_CYCLES)
  ) u_seq (
    .clk          (clk),
    .rst          (rst),
    .ctl          (ctl),
    .id_hit       (id_hit),
    .addr         (addr[MAIN_AW-1:0]),
    .din          (dq_in),
    .busy         (busy),
    .poll         (poll),
    .wr_en        (wr_en),
    .wr_id        (wr_id),
    .wr_main_addr (wr_main_addr),
    .wr_id_addr   (wr_id_addr),
    .wr_data      (wr_data)
  );

  nvbyte_store #(.DATA_W(DATA_W), .MAIN_AW(MAIN_AW), .ID_AW(ID_AW)) u_store (
    .clk          (clk),
    .wr_en        (wr_en),
    .wr_id        (wr_id),
    .wr_main_addr (wr_main_addr),
    .wr_id_addr   (wr_id_addr),
    .wr_data      (wr_data),
    .rd_id        (id_hit),
    .rd_main_addr (addr[MAIN_AW-1:0]),
    .rd_id_addr   (addr[ID_AW-1:0]),
    .rdata        (rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dq_oe  <= 1'b0;
      dq_out <= '0;
    end else begin
      dq_oe  <= rd_en;
      dq_out <= !rd_en ? '0 : (busy ? poll : rdata);
    end
  end

  assign busy_pull = busy;

endmodule

// File: rtl/nvbyte_ctrl_chk.sv
module nvbyte_ctrl_chk #(
  parameter int DATA_W       = 8,
  parameter int MAIN_AW      = 8,
  parameter int WR_CYCLES    = 25000,
  parameter int PWRUP_CYCLES = 625000
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              oe_n,
  input logic              dq_oe,
  input logic [DATA_W-2:0] dq_low,
  input logic              busy_pull
);

  localparam int MAXRUN = (WR_CYCLES > (1 << MAIN_AW)) ? WR_CYCLES : (1 << MAIN_AW);
  localparam int RW     = $clog2(MAXRUN + 2);
  localparam int UW     = $clog2(PWRUP_CYCLES + 1);

  logic [RW-1:0] run;
  logic [UW-1:0] up_cnt;

  always_ff @(posedge clk) begin
    if (rst)                            up_cnt <= '0;
    else if (up_cnt < UW'(PWRUP_CYCLES)) up_cnt <= up_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || !busy_pull)         run <= '0;
    else if (run != {RW{1'b1}})   run <= run + 1'b1;
  end

  assert_oe_gate_R2: assert property (@(posedge clk) disable iff (rst)
    (oe_n && $past(oe_n) && $past(oe_n, 2) && $past(oe_n, 3)) |-> !dq_oe);

  assert_cs_gate_R2: assert property (@(posedge clk) disable iff (rst)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !dq_oe);

  assert_busy_len_R5: assert property (@(posedge clk) disable iff (rst)
    run <= RW'(MAXRUN));

  assert_poll_low_R6: assert property (@(posedge clk) disable iff (rst)
    (busy_pull && $past(busy_pull) && dq_oe) |-> (dq_low == '0));

  assert_lockout_R8: assert property (@(posedge clk) disable iff (rst)
    (up_cnt < UW'(PWRUP_CYCLES)) |-> !busy_pull);

endmodule

bind nvbyte_ctrl nvbyte_ctrl_chk #(
  .DATA_W(DATA_W), .MAIN_AW(MAIN_AW),
  .WR_CYCLES(WR_CYCLES), .PWRUP_CYCLES(PWRUP_CYCLES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs_n      (cs_n),
  .oe_n      (oe_n),
  .dq_oe     (dq_oe),
  .dq_low    (dq_out[DATA_W-2:0]),
  .busy_pull (busy_pull)
);

// File: tb/nvbyte_ctrl_tb.sv
module nvbyte_ctrl_tb;

  localparam int WR   = 40;
  localparam int PWR  = 100;
  localparam int CLR  = 20;
  localparam int MAW  = 6;
  localparam int DEP  = 1 << MAW;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, clr_hv = 1'b0, id_sel = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0]  dq_in = '0;
  logic [7:0]  dq_out;
  logic        dq_oe, busy_pull;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  nvbyte_ctrl #(
    .ADDR_W(13), .DATA_W(8), .MAIN_AW(MAW), .ID_AW(5),
    .WR_CYCLES(WR), .PWRUP_CYCLES(PWR), .CLR_CYCLES(CLR)
  ) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .clr_hv(clr_hv), .id_sel(id_sel), .addr(addr), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .busy_pull(busy_pull)
  );

  // {id_sel, cs-controlled, addr[12:0], data[7:0]}
  localparam logic [22:0] VEC [8] = '{
    {1'b0, 1'b0, 13'h0000, 8'h00},
    {1'b0, 1'b1, 13'h003F, 8'h7E},
    {1'b0, 1'b0, 13'h0020, 8'h3C},
    {1'b1, 1'b1, 13'h1FE0, 8'hA5},
    {1'b1, 1'b0, 13'h1FFF, 8'h5A},
    {1'b0, 1'b1, 13'h0011, 8'h81},
    {1'b1, 1'b0, 13'h0007, 8'h96},
    {1'b0, 1'b0, 13'h1FE1, 8'hC3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one write strobe, then count the busy cycles that follow
  task automatic wr(input logic ce_ctrl, input logic idm, input logic [12:0] a,
                    input logic [7:0] d, input logic oe_low, output int nbusy);
    @(negedge clk);
    id_sel = idm; addr = a; dq_in = d; oe_n = oe_low ? 1'b0 : 1'b1;
    if (ce_ctrl) we_n = 1'b0; else cs_n = 1'b0;
    cyc(3);
    if (ce_ctrl) cs_n = 1'b0; else we_n = 1'b0;
    cyc(6);
    if (ce_ctrl) cs_n = 1'b1; else we_n = 1'b1;
    nbusy = 0;
    for (int i = 0; i < WR + 30; i++) begin
      @(negedge clk);
      if (busy_pull) nbusy++;
    end
    cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; id_sel = 1'b0;
    cyc(2);
  endtask

  task automatic rd(input logic idm, input logic [12:0] a, output logic [7:0] q,
                    output logic oe);
    @(negedge clk);
    id_sel = idm; addr = a; we_n = 1'b1; cs_n = 1'b0; oe_n = 1'b0;
    cyc(6);
    q = dq_out; oe = dq_oe;
    cs_n = 1'b1; oe_n = 1'b1; id_sel = 1'b0;
    cyc(5);
  endtask

  task automatic hold_clear(input int n, output int nbusy);
    @(negedge clk);
    clr_hv = 1'b1; cs_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    nbusy = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (busy_pull) nbusy++;
    end
    clr_hv = 1'b0; cs_n = 1'b1; we_n = 1'b1;
    for (int i = 0; i < DEP + 20; i++) begin
      @(negedge clk);
      if (busy_pull) nbusy++;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] q;
    logic       oe;
    int         nb;

    // R11: reset state
    cyc(4);
    chk("R11 busy", 32'(busy_pull), 0);
    chk("R11 dq_oe", 32'(dq_oe), 0);
    chk("R11 dq_out", 32'(dq_out), 0);
    @(negedge clk); rst = 1'b0;

    // R8: write inside the lockout window is refused
    wr(1'b0, 1'b0, 13'h0003, 8'h11, 1'b0, nb);
    chk("R8 no busy in lockout", 32'(nb), 0);
    cyc(30);

    // R5: accepted write holds busy for exactly WR cycles
    wr(1'b0, 1'b0, 13'h0005, 8'h12, 1'b0, nb);
    chk("R5 busy length", 32'(nb), WR);
    rd(1'b0, 13'h0005, q, oe);
    chk("R1 drive enable", 32'(oe), 1);
    chk("R5 data after write", 32'(q), 8'h12);

    // R9: short erase pulse has no effect
    hold_clear(CLR / 2, nb);
    chk("R9 short pulse busy", 32'(nb), 0);
    rd(1'b0, 13'h0005, q, oe);
    chk("R9 short pulse keeps data", 32'(q), 8'h12);

    // R9: long erase pulse sweeps the array
    hold_clear(CLR + 10, nb);
    chk("R9 sweep busy length", 32'(nb), DEP);
    rd(1'b0, 13'h0005, q, oe);
    chk("R9 erased 05", 32'(q), 8'hFF);
    rd(1'b0, 13'(DEP - 1), q, oe);
    chk("R9 erased last", 32'(q), 8'hFF);
    rd(1'b0, 13'h0003, q, oe);
    chk("R8 lockout write left no data", 32'(q), 8'hFF);

    // table walk: R1 R4 R5 R10
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][21], VEC[i][22], VEC[i][20:8], VEC[i][7:0], 1'b0, nb);
      chk("R5 busy length table", 32'(nb), WR);
      rd(VEC[i][22], VEC[i][20:8], q, oe);
      chk(VEC[i][21] ? "R4 cs-controlled readback" : "R1 readback", 32'(q), 32'(VEC[i][7:0]));
    end
    for (int i = 0; i < 8; i++) begin
      rd(VEC[i][22], VEC[i][20:8], q, oe);
      chk("R10 area isolation", 32'(q), 32'(VEC[i][7:0]));
    end

    // R3: address taken at the falling edge, data at the rising edge
    @(negedge clk);
    addr = 13'h000A; dq_in = 8'h11; cs_n = 1'b0; oe_n = 1'b1;
    cyc(3); we_n = 1'b0;
    cyc(5); addr = 13'h000B; dq_in = 8'h22;
    cyc(3); we_n = 1'b1;
    cyc(6); dq_in = 8'h33;
    cyc(WR + 10); cs_n = 1'b1;
    rd(1'b0, 13'h000A, q, oe);
    chk("R3 addr at fall data at rise", 32'(q), 8'h22);
    rd(1'b0, 13'h000B, q, oe);
    chk("R3 late address unused", 32'(q), 8'hFF);

    // R6: status pattern during the timed cycle
    @(negedge clk);
    addr = 13'h0012; dq_in = 8'h5A; cs_n = 1'b0; oe_n = 1'b1;
    cyc(3); we_n = 1'b0;
    cyc(6); we_n = 1'b1;
    cyc(5); oe_n = 1'b0;
    cyc(6);
    chk("R6 busy during poll", 32'(busy_pull), 1);
    chk("R6 poll pattern", 32'(dq_out), 8'h80);
    oe_n = 1'b1; cs_n = 1'b1;
    cyc(WR + 10);
    rd(1'b0, 13'h0012, q, oe);
    chk("R6 true data after cycle", 32'(q), 8'h5A);

    // R7: output enable low inhibits the write
    wr(1'b0, 1'b0, 13'h0011, 8'h00, 1'b1, nb);
    chk("R7 oe low no busy", 32'(nb), 0);
    rd(1'b0, 13'h0011, q, oe);
    chk("R7 oe low keeps data", 32'(q), 8'h81);

    // R7: strobe during busy is ignored
    @(negedge clk);
    addr = 13'h0030; dq_in = 8'h44; cs_n = 1'b0; oe_n = 1'b1;
    cyc(3); we_n = 1'b0;
    cyc(6); we_n = 1'b1;
    cyc(6); addr = 13'h0031; dq_in = 8'h55; we_n = 1'b0;
    cyc(6); we_n = 1'b1;
    cyc(6); cs_n = 1'b1;
    cyc(WR + 20);
    rd(1'b0, 13'h0031, q, oe);
    chk("R7 busy write ignored", 32'(q), 8'hFF);
    rd(1'b0, 13'h0030, q, oe);
    chk("R7 first write kept", 32'(q), 8'h44);

    // R2: bus released when either enable is high
    @(negedge clk);
    cs_n = 1'b0; oe_n = 1'b1; we_n = 1'b1; addr = 13'h0030;
    cyc(6);
    chk("R2 oe high dq_oe", 32'(dq_oe), 0);
    chk("R2 oe high dq_out", 32'(dq_out), 0);
    cs_n = 1'b1; oe_n = 1'b0;
    cyc(6);
    chk("R2 cs high dq_oe", 32'(dq_oe), 0);
    oe_n = 1'b1;
    cyc(4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule